// File: doc/BRIEF.md
# Laser Current Monitor Interrupt Unit

This block watches two signed samples from a laser bias loop: the measured current level and its change between measurements. It compares each one against an upper and a lower limit. Every comparison result is stored in a status register whenever a new sample pair arrives. Software can poll that register at any time, whatever the interrupt setup. Comparison results that software has selected also set sticky interrupt flags. The flags stay set until software writes a one to the matching bit.

The flags are combined onto a single interrupt request. That request drives an active-low open-drain pad, and the block only supplies the pull-down enable, so several devices can share one wired line. An enable register gates each flag onto the request line. Flags listed in a build-time non-maskable set reach the line whatever the enable register holds. By default the only such flag is current overrun, which is a safety condition.

Top module: `lsr_irq_unit`

## Requirements
- R1: After reset, the select, enable, flag and status registers read as zero and `irq_oe_o` is low.
- R2: A sample is taken on any clock edge where `smp_vld_i` is high. All comparisons are signed and strict. Status bit 0 is `cur_i > cur_hi_i`, bit 1 is `cur_i < cur_lo_i`, bit 2 is `dlt_i > dlt_hi_i` and bit 3 is `dlt_i < dlt_lo_i`. Status takes these four values at that edge, whatever the select and enable registers hold.
- R3: On a sample edge, flag bit i is set only when comparison i is true and select bit i is set. Once set, the flag stays set until it is cleared.
- R4: A write to address 2 clears every flag bit whose write data bit is 1. Flag bits whose write data bit is 0 are left unchanged.
- R5: If a flag is cleared on the same edge where a new sample sets it, the flag ends up set.
- R6: `irq_oe_o` is high, meaning the line is pulled low, exactly when some flag is set and that flag is either enabled or non-maskable. It follows the flags in the same cycle.
- R7: Flags in the non-maskable set, which by default is bit 0 alone, drive `irq_oe_o` even when their enable bit is 0.
- R8: Address 0 is the select register and address 1 is the enable register; both can be written and read. Address 2 holds the flags and address 3 holds the status. When `rd_en_i` is high, `rdata_o` is loaded from the register at `addr_i` on that edge, with all bits above bit 3 reading as zero. At other times `rdata_o` holds its value. Writes to address 3 are ignored.
- R9: While `smp_vld_i` is low, the status register does not change and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | New sample pair present |
| cur_i | input | 10 | Signed current sample |
| dlt_i | input | 10 | Signed delta-current sample |
| cur_hi_i | input | 10 | Signed current overrun limit |
| cur_lo_i | input | 10 | Signed current under-run limit |
| dlt_hi_i | input | 10 | Signed delta overrun limit |
| dlt_lo_i | input | 10 | Signed delta under-run limit |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_oe_o | output | 1 | Pull-down enable for the open-drain interrupt line |

## Verification
The assertions assume that the limit inputs stay steady around each sample edge. They also assume that a write to the flag address is the only clearing action, so a cleared flag comes back only through a selected, valid sample. The stimulus changes limits only while `smp_vld_i` is low and drives every strobe for exactly one clock. Clear and sample fall on the same edge only in the set-wins case.

// File: rtl/lsr_irq_pkg.sv
package lsr_irq_pkg;
  localparam int unsigned NUM_COND = 4;
  localparam int unsigned ADDR_W   = 2;

  // condition bit positions, shared by status, flags, select and enable
  localparam int unsigned C_CUR_OVR = 0;
  localparam int unsigned C_CUR_UND = 1;
  localparam int unsigned C_DLT_OVR = 2;
  localparam int unsigned C_DLT_UND = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_SEL  = 2'd0,
    REG_EN   = 2'd1,
    REG_FLAG = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/lsr_irq_cmp.sv
module lsr_irq_cmp #(
  parameter int unsigned W = 10
) (
  input  logic signed [W-1:0] val_i,
  input  logic signed [W-1:0] hi_i,
  input  logic signed [W-1:0] lo_i,
  output logic                over_o,
  output logic                under_o
);
  assign over_o  = val_i > hi_i;
  assign under_o = val_i < lo_i;
endmodule

// File: rtl/lsr_irq_flags.sv
module lsr_irq_flags #(
  parameter int unsigned NC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_vld_i,
  input  logic [NC-1:0] cond_i,
  input  logic [NC-1:0] sel_i,
  input  logic          clr_i,
  input  logic [NC-1:0] clr_mask_i,
  output logic [NC-1:0] flag_o,
  output logic [NC-1:0] status_o
);
  logic [NC-1:0] flag_q, flag_d, set_v, clr_v;
  logic [NC-1:0] stat_q;

  assign set_v  = smp_vld_i ? (cond_i & sel_i) : '0;
  assign clr_v  = clr_i ? clr_mask_i : '0;
  // set applied after clear: a fresh event survives a simultaneous clear
  assign flag_d = (flag_q & ~clr_v) | set_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      stat_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (smp_vld_i) stat_q <= cond_i;
    end
  end

  assign flag_o   = flag_q;
  assign status_o = stat_q;
endmodule

// File: rtl/lsr_irq_regs.sv
module lsr_irq_regs
  import lsr_irq_pkg::*;
#(
  parameter int unsigned NC = 4,
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NC-1:0]     flag_i,
  input  logic [NC-1:0]     status_i,
  output logic [NC-1:0]     sel_o,
  output logic [NC-1:0]     en_o,
  output logic              clr_o,
  output logic [NC-1:0]     clr_mask_o,
  output logic [DW-1:0]     rdata_o
);
  localparam int unsigned PADW = DW - NC;

  logic [NC-1:0] sel_q, en_q, rd_sel;
  logic [DW-1:0] rdata_q;
  reg_addr_e     a;

  assign a = reg_addr_e'(addr_i);

  always_comb begin
    unique case (a)
      REG_SEL:  rd_sel = sel_q;
      REG_EN:   rd_sel = en_q;
      REG_FLAG: rd_sel = flag_i;
      default:  rd_sel = status_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      en_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en_i && a == REG_SEL) sel_q <= wdata_i[NC-1:0];
      if (wr_en_i && a == REG_EN)  en_q  <= wdata_i[NC-1:0];
      if (rd_en_i) rdata_q <= {{PADW{1'b0}}, rd_sel};
    end
  end

  assign clr_o      = wr_en_i && (a == REG_FLAG);
  assign clr_mask_o = wdata_i[NC-1:0];
  assign sel_o      = sel_q;
  assign en_o       = en_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/lsr_irq_unit.sv
module lsr_irq_unit
  import lsr_irq_pkg::*;
#(
  parameter int unsigned         W     = 10,
  parameter int unsigned         DW    = 8,
  parameter logic [NUM_COND-1:0] NMASK = 4'b0001
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_vld_i,
  input  logic signed [W-1:0] cur_i,
  input  logic signed [W-1:0] dlt_i,
  input  logic signed [W-1:0] cur_hi_i,
  input  logic signed [W-1:0] cur_lo_i,
  input  logic signed [W-1:0] dlt_hi_i,
  input  logic signed [W-1:0] dlt_lo_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic                irq_oe_o
);
  localparam int unsigned NCH = NUM_COND / 2;

  logic signed [W-1:0] ch_val [NCH];
  logic signed [W-1:0] ch_hi  [NCH];
  logic signed [W-1:0] ch_lo  [NCH];
  logic [NUM_COND-1:0] cond;
  logic [NUM_COND-1:0] sel_q, en_q, flag_q, status_q, clr_mask;
  logic                clr;

  assign ch_val[0] = cur_i;    assign ch_val[1] = dlt_i;
  assign ch_hi[0]  = cur_hi_i; assign ch_hi[1]  = dlt_hi_i;
  assign ch_lo[0]  = cur_lo_i; assign ch_lo[1]  = dlt_lo_i;

  // channel k feeds condition bits 2k (over) and 2k+1 (under)
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    lsr_irq_cmp #(.W(W)) u_cmp (
      .val_i  (ch_val[k]),
      .hi_i   (ch_hi[k]),
      .lo_i   (ch_lo[k]),
      .over_o (cond[2*k]),
      .under_o(cond[2*k+1])
    );
  end

  lsr_irq_flags #(.NC(NUM_COND)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_vld_i (smp_vld_i),
    .cond_i    (cond),
    .sel_i     (sel_q),
    .clr_i     (clr),
    .clr_mask_i(clr_mask),
    .flag_o    (flag_q),
    .status_o  (status_q)
  );

  lsr_irq_regs #(.NC(NUM_COND), .DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .flag_i    (flag_q),
    .status_i  (status_q),
    .sel_o     (sel_q),
    .en_o      (en_q),
    .clr_o     (clr),
    .clr_mask_o(clr_mask),
    .rdata_o   (rdata_o)
  );

  assign irq_oe_o = |(flag_q & (en_q | NMASK));
endmodule

// File: rtl/lsr_irq_chk.sv
module lsr_irq_chk
  import lsr_irq_pkg::*;
#(
  parameter int unsigned         W     = 10,
  parameter int unsigned         DW    = 8,
  parameter logic [NUM_COND-1:0] NMASK = 4'b0001
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                smp_vld_i,
  input logic signed [W-1:0] cur_i,
  input logic signed [W-1:0] cur_hi_i,
  input logic                wr_en_i,
  input logic                rd_en_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DW-1:0]       rdata_o,
  input logic                irq_oe_o,
  input logic [NUM_COND-1:0] flag_q,
  input logic [NUM_COND-1:0] sel_q,
  input logic [NUM_COND-1:0] status_q
);
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 2'd2) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  a_r3_sel_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(sel_q)) == '0));

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && sel_q[C_CUR_OVR] && (cur_i > cur_hi_i)) |=> flag_q[C_CUR_OVR]);

  a_r6_idle_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q == '0) |-> !irq_oe_o);

  a_r7_nonmask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & NMASK) != '0) |-> irq_oe_o);

  a_r8_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  a_r9_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> ((flag_q & ~$past(flag_q)) == '0));

  a_r9_stat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> $stable(status_q));
endmodule

bind lsr_irq_unit lsr_irq_chk #(.W(W), .DW(DW), .NMASK(NMASK)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .smp_vld_i(smp_vld_i),
  .cur_i    (cur_i),
  .cur_hi_i (cur_hi_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .irq_oe_o (irq_oe_o),
  .flag_q   (flag_q),
  .sel_q    (sel_q),
  .status_q (status_q)
);

// File: tb/lsr_irq_unit_test.sv
module lsr_irq_unit_test;
  localparam int W  = 10;
  localparam int DW = 8;
  localparam logic [3:0] NM = 4'b0001;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic                smp_vld = 0, wr_en = 0, rd_en = 0;
  logic signed [W-1:0] cur = '0, dlt = '0, cur_hi = '0, cur_lo = '0, dlt_hi = '0, dlt_lo = '0;
  logic [1:0]          addr = '0;
  logic [DW-1:0]       wdata = '0, rdata;
  logic                irq_oe;

  lsr_irq_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .smp_vld_i(smp_vld),
    .cur_i(cur), .dlt_i(dlt), .cur_hi_i(cur_hi), .cur_lo_i(cur_lo),
    .dlt_hi_i(dlt_hi), .dlt_lo_i(dlt_lo),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_oe_o(irq_oe)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] m_sel = 0, m_en = 0, m_flag = 0, m_stat = 0;
  int ch = 0, cl = 0, dh = 0, dl = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] cond_of(int c, int d);
    return {d < dl, d > dh, c < cl, c > ch};
  endfunction

  task automatic set_lim(int a, int b, int c, int d);
    @(negedge clk);
    ch = a; cl = b; dh = c; dl = d;
    cur_hi = W'(a); cur_lo = W'(b); dlt_hi = W'(c); dlt_lo = W'(d);
  endtask

  task automatic do_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    case (a)
      2'd0: m_sel = d[3:0];
      2'd1: m_en = d[3:0];
      2'd2: m_flag = m_flag & ~d[3:0];
      default: ;
    endcase
  endtask

  task automatic do_rd(logic [1:0] a, output logic [7:0] q);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    q = rdata;
  endtask

  task automatic do_smp(int c, int d);
    logic [3:0] cc;
    cc = cond_of(c, d);
    @(negedge clk); smp_vld = 1; cur = W'(c); dlt = W'(d);
    @(negedge clk); smp_vld = 0;
    m_stat = cc;
    m_flag = m_flag | (cc & m_sel);
  endtask

  task automatic smp_clr(int c, int d, logic [3:0] mask);
    logic [3:0] cc;
    cc = cond_of(c, d);
    @(negedge clk); smp_vld = 1; cur = W'(c); dlt = W'(d);
    wr_en = 1; addr = 2'd2; wdata = {4'b0, mask};
    @(negedge clk); smp_vld = 0; wr_en = 0;
    m_stat = cc;
    m_flag = (m_flag & ~mask) | (cc & m_sel);
  endtask

  task automatic chk_state(string rs, string rf, string ri);
    logic [7:0] q;
    do_rd(2'd3, q); chk(rs, int'(q), int'({4'b0, m_stat}));
    do_rd(2'd2, q); chk(rf, int'(q), int'({4'b0, m_flag}));
    chk(ri, int'(irq_oe), int'(|(m_flag & (m_en | NM))));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    chk("R1 irq", int'(irq_oe), 0);
    for (int a = 0; a < 4; a++) begin
      do_rd(2'(a), q); chk("R1 reg", int'(q), 0);
    end

    // R8 register access, upper bits zero, status read-only
    do_wr(2'd0, 8'hA5); do_rd(2'd0, q); chk("R8 sel", int'(q), 8'h05);
    do_wr(2'd1, 8'hFC); do_rd(2'd1, q); chk("R8 en", int'(q), 8'h0C);
    do_wr(2'd3, 8'hFF); do_rd(2'd3, q); chk("R8 stat ro", int'(q), 0);

    // R2/R3 full current sweep with nothing selected: status live, flags idle
    do_wr(2'd0, 8'h00); do_wr(2'd1, 8'h00);
    set_lim(100, -100, 50, -50);
    for (int c = -512; c < 512; c++) begin
      do_smp(c, 0);
      chk_state("R2 status", "R3 unselected", "R6 irq");
    end

    // R2/R3/R4/R7 full delta sweep, all selected, none enabled
    do_wr(2'd0, 8'h0F);
    set_lim(0, -1, 17, -33);
    for (int d = -512; d < 512; d++) begin
      do_smp(((d & 1) != 0) ? 5 : -5, d);
      chk_state("R2 status", "R3 flags", "R7 nonmask");
      do_wr(2'd2, 8'h0F);
      chk("R4 clear all", int'(irq_oe), 0);
    end

    // R9 inputs move without valid: status and flags unchanged
    do_smp(511, -512);
    @(negedge clk); cur = -W'(300); dlt = W'(200);
    repeat (3) @(negedge clk);
    chk_state("R9 status", "R9 flags", "R9 irq");

    // R4/R6 every enable against every partial clear
    for (int e = 0; e < 16; e++) begin
      do_wr(2'd1, 8'(e));
      for (int m = 0; m < 16; m++) begin
        do_smp(511, 511);
        do_smp(-512, -512);
        do_wr(2'd2, 8'(m));
        chk("R6 irq", int'(irq_oe), int'(|(m_flag & (4'(e) | NM))));
        do_rd(2'd2, q); chk("R4 partial", int'(q), int'({4'b0, 4'hF & ~4'(m)}));
        do_wr(2'd2, 8'h0F);
      end
    end

    // R5 set wins over same-edge clear
    do_wr(2'd1, 8'h00);
    smp_clr(-512, 0, 4'hF);
    chk_state("R5 status", "R5 set wins", "R5 irq");
    smp_clr(0, 511, 4'h3);
    chk_state("R5 status", "R5 mixed", "R5 irq");

    // R3 sticky across later quiet samples
    do_smp(0, 0);
    chk_state("R3 status", "R3 sticky", "R3 irq");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule